// File: doc/BRIEF.md
# UART Automatic Modem Flow Control

This block performs hardware handshaking for one UART channel without software help. On the receive side it watches the fill count of the receive FIFO and drives a "ready to receive" output LOW while there is room. It drives that output HIGH once the count reaches an upper threshold, and drives it LOW again only after the host has drained the FIFO to a lower threshold. Between the two thresholds the output keeps its previous state. On the transmit side it synchronizes the peer's "clear to send" input and gates the start of each new character. A character already in the shifter always runs to its stop bit.

One configuration bit chooses which pin pair carries the handshake: the RTS/CTS pair or the DTR/DSR pair. The same bit also picks the pair that the flow-control interrupt watches. The interrupt latches when the watched input is deasserted, or when the receive-ready output trips HIGH, each under its own enable. A read strobe clears it. The enable bits and the pair select can be changed only while an unlock bit in the feature byte is set. The FIFOs, the framing and the baud timing live elsewhere and appear here only as a count and two handshake signals. Elaboration stops with an error if the upper threshold is not strictly above the lower one.

Top module: `uart_autoflow`

## Requirements
- R1: After reset both feature enables, both interrupt enables, the unlock bit and the pair select are 0 and the status is clear. The selected output `rts_n` is therefore LOW, `dtr_n` is HIGH, `irq_flow` is 0, and `tx_start` follows `tx_req & ~tx_busy`.
- R2: In the feature byte, bit 6 enables automatic receive-side control and bit 7 enables automatic transmit-side gating. The two act independently. With bit 6 clear the selected output stays LOW. With bit 7 clear the flow input never holds off a character.
- R3: With automatic receive control on, `rx_level >= RTS_HI` at a rising edge drives the selected output HIGH after that edge. Receive data is still accepted.
- R4: The selected output returns LOW after an edge at which `rx_level <= RTS_LO`. For levels strictly between the thresholds it keeps its state.
- R5: `rx_irq` is high exactly while `rx_level >= RX_TRIG`, where `RX_TRIG` lies below `RTS_HI`.
- R6: `tx_start` is `tx_req & ~tx_busy`, forced low while automatic transmit gating is on and the synchronized flow input is HIGH. The pin passes through two flops, so a change takes effect after the second rising edge. `tx_start` is never high while `tx_busy` is high, so a character in flight always completes.
- R7: Bit 2 of the modem-control byte selects the pair: 0 selects RTS/CTS and 1 selects DTR/DSR. The unselected output is held HIGH and the unselected input is ignored.
- R8: `irq_flow` sets one edge after the synchronized selected input first reads HIGH, if interrupt-enable bit 7 is 1. It also sets at the edge where the receive output trips HIGH, if interrupt-enable bit 6 and automatic receive control are 1. `stat_rd` clears it at the next edge, and a set in the same cycle wins over the clear.
- R9: Writes to interrupt-enable bits 7:6 and to modem-control bit 2 take effect only while feature bit 4, as already stored, is 1. Writes to the feature byte are never gated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdata | input | 8 | Write data shared by the three configuration bytes |
| feat_we | input | 1 | Write strobe for the feature byte (bits 7, 6, 4) |
| ien_we | input | 1 | Write strobe for the interrupt-enable byte (bits 7, 6) |
| mctl_we | input | 1 | Write strobe for the modem-control byte (bit 2) |
| stat_rd | input | 1 | Status read strobe; clears the flow interrupt |
| rx_level | input | LVL_W | Receive FIFO fill count |
| tx_req | input | 1 | A character is waiting to be sent |
| tx_busy | input | 1 | Shifter busy until its stop bit is out |
| cts_n | input | 1 | Clear-to-send input, active low |
| dsr_n | input | 1 | Data-set-ready input, active low |
| rts_n | output | 1 | Request-to-send output, active low |
| dtr_n | output | 1 | Data-terminal-ready output, active low |
| tx_start | output | 1 | Start the next character |
| rx_irq | output | 1 | Receive trigger level reached |
| irq_flow | output | 1 | Latched flow-control interrupt |

## Verification
The bench builds the block with a 5-bit level and thresholds of 12 and 4 with a trigger of 6. Sweeping the count over 0 to 31 therefore visits the full range, both thresholds and the hysteresis band between them in a few dozen cycles. A reference model compares every output on every cycle. The stimulus covers both pair selections, locked and unlocked writes, status reads that collide with new events, and flow-input toggles that land on busy characters.

// File: rtl/uart_autoflow.sv
module uart_autoflow #(
  parameter int LVL_W   = 6,
  parameter int RTS_HI  = 24,
  parameter int RTS_LO  = 8,
  parameter int RX_TRIG = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       wdata,
  input  logic             feat_we,
  input  logic             ien_we,
  input  logic             mctl_we,
  input  logic             stat_rd,
  input  logic [LVL_W-1:0] rx_level,
  input  logic             tx_req,
  input  logic             tx_busy,
  input  logic             cts_n,
  input  logic             dsr_n,
  output logic             rts_n,
  output logic             dtr_n,
  output logic             tx_start,
  output logic             rx_irq,
  output logic             irq_flow
);

  localparam logic [LVL_W-1:0] HI_L   = LVL_W'(RTS_HI);
  localparam logic [LVL_W-1:0] LO_L   = LVL_W'(RTS_LO);
  localparam logic [LVL_W-1:0] TRIG_L = LVL_W'(RX_TRIG);

  if (RTS_HI <= RTS_LO) begin : g_thr_bad
    $error("RTS_HI must be strictly greater than RTS_LO");
  end

  logic       auto_rts, auto_cts, unlock;
  logic       ien_in, ien_out, pair_sel;
  logic [1:0] cts_q, dsr_q;
  logic       in_prev, full_q, stat_q;
  logic       in_s, full_d, set_ev, flow_out_n;
  logic       unused_bits;

  assign unused_bits = ^{wdata[5], wdata[3], wdata[1:0]};

  assign in_s   = pair_sel ? dsr_q[1] : cts_q[1];
  assign full_d = (rx_level >= HI_L) ? 1'b1 :
                  (rx_level <= LO_L) ? 1'b0 : full_q;
  assign set_ev = (ien_in & in_s & ~in_prev) |
                  (ien_out & auto_rts & full_d & ~full_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_rts <= 1'b0;
      auto_cts <= 1'b0;
      unlock   <= 1'b0;
      ien_in   <= 1'b0;
      ien_out  <= 1'b0;
      pair_sel <= 1'b0;
    end else begin
      if (feat_we) begin
        auto_cts <= wdata[7];
        auto_rts <= wdata[6];
        unlock   <= wdata[4];
      end
      if (ien_we && unlock) begin
        ien_in  <= wdata[7];
        ien_out <= wdata[6];
      end
      if (mctl_we && unlock) pair_sel <= wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_q   <= 2'b00;
      dsr_q   <= 2'b00;
      in_prev <= 1'b0;
      full_q  <= 1'b0;
      stat_q  <= 1'b0;
    end else begin
      cts_q   <= {cts_q[0], cts_n};
      dsr_q   <= {dsr_q[0], dsr_n};
      in_prev <= in_s;
      full_q  <= full_d;
      if (set_ev)       stat_q <= 1'b1;
      else if (stat_rd) stat_q <= 1'b0;
    end
  end

  assign flow_out_n = auto_rts & full_q;
  assign rts_n      = pair_sel ? 1'b1 : flow_out_n;
  assign dtr_n      = pair_sel ? flow_out_n : 1'b1;
  assign tx_start   = tx_req & ~tx_busy & ~(auto_cts & in_s);
  assign rx_irq     = rx_level >= TRIG_L;
  assign irq_flow   = stat_q;

endmodule

// File: rtl/uart_autoflow_chk.sv
module uart_autoflow_chk #(
  parameter int LVL_W   = 6,
  parameter int RTS_HI  = 24,
  parameter int RTS_LO  = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             feat_we,
  input logic             ien_we,
  input logic             mctl_we,
  input logic [LVL_W-1:0] rx_level,
  input logic             tx_req,
  input logic             tx_busy,
  input logic             rts_n,
  input logic             dtr_n,
  input logic             tx_start,
  input logic             irq_flow,
  input logic             auto_rts,
  input logic             unlock,
  input logic             ien_in,
  input logic             ien_out,
  input logic             pair_sel
);

  // R3
  rts_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rx_level) >= RTS_HI && auto_rts && !pair_sel && !feat_we && !mctl_we) |=> rts_n);

  // R4
  rts_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rx_level) <= RTS_LO) |=> (!rts_n || !dtr_n));

  // R7
  one_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rts_n && !dtr_n));

  // R6
  no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> (tx_req && !tx_busy));

  // R8
  irq_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_flow) |-> ($past(ien_in) || $past(ien_out)));

  // R9
  ien_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_we && !unlock) |=> ($stable(ien_in) && $stable(ien_out)));

  // R9
  sel_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mctl_we && !unlock) |=> $stable(pair_sel));

endmodule

bind uart_autoflow uart_autoflow_chk #(
  .LVL_W(LVL_W), .RTS_HI(RTS_HI), .RTS_LO(RTS_LO)
) u_chk (
  .clk(clk), .rst_n(rst_n), .feat_we(feat_we), .ien_we(ien_we),
  .mctl_we(mctl_we), .rx_level(rx_level), .tx_req(tx_req),
  .tx_busy(tx_busy), .rts_n(rts_n), .dtr_n(dtr_n), .tx_start(tx_start),
  .irq_flow(irq_flow), .auto_rts(auto_rts), .unlock(unlock),
  .ien_in(ien_in), .ien_out(ien_out), .pair_sel(pair_sel)
);

// File: tb/uart_autoflow_bench.sv
module uart_autoflow_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LW = 5, HI = 12, LO = 4, TRIG = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] wdata = '0;
  logic feat_we = 0, ien_we = 0, mctl_we = 0, stat_rd = 0;
  logic [LW-1:0] rx_level = '0;
  logic tx_req = 0, tx_busy = 0, cts_n = 0, dsr_n = 0;
  logic rts_n, dtr_n, tx_start, rx_irq, irq_flow;

  int vectors = 0, miscompares = 0, cyc = 0;

  uart_autoflow #(.LVL_W(LW), .RTS_HI(HI), .RTS_LO(LO), .RX_TRIG(TRIG)) u_uart_autoflow (
    .clk(clk), .rst_n(rst_n), .wdata(wdata), .feat_we(feat_we), .ien_we(ien_we),
    .mctl_we(mctl_we), .stat_rd(stat_rd), .rx_level(rx_level), .tx_req(tx_req),
    .tx_busy(tx_busy), .cts_n(cts_n), .dsr_n(dsr_n), .rts_n(rts_n), .dtr_n(dtr_n),
    .tx_start(tx_start), .rx_irq(rx_irq), .irq_flow(irq_flow));

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference: pin history as queues, state as plain bits
  bit m_arts, m_acts, m_unl, m_ie7, m_ie6, m_sel, m_full, m_stat, m_prev;
  bit cq[$], dq[$];

  function automatic bit m_in();
    return m_sel ? dq[0] : cq[0];
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      {m_arts, m_acts, m_unl, m_ie7, m_ie6, m_sel, m_full, m_stat, m_prev} = '0;
      cq = '{0, 0}; dq = '{0, 0};
    end else begin
      bit nf, s, inv;
      inv = m_in();
      nf = (int'(rx_level) >= HI) ? 1'b1 : (int'(rx_level) <= LO) ? 1'b0 : m_full;
      s = (m_ie7 && inv && !m_prev) || (m_ie6 && m_arts && nf && !m_full);
      if (s) m_stat = 1; else if (stat_rd) m_stat = 0;
      m_prev = inv; m_full = nf;
      void'(cq.pop_front()); cq.push_back(cts_n);
      void'(dq.pop_front()); dq.push_back(dsr_n);
      if (ien_we && m_unl) begin m_ie7 = wdata[7]; m_ie6 = wdata[6]; end
      if (mctl_we && m_unl) m_sel = wdata[2];
      if (feat_we) begin m_acts = wdata[7]; m_arts = wdata[6]; m_unl = wdata[4]; end
    end
  end

  task automatic chk(input string req, input string nm, input logic act, input logic exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0b expected=%0b cycle=%0d", req, nm, act, exp, cyc);
    end
  endtask

  task automatic compare();
    bit outv;
    outv = m_arts && m_full;
    vectors++;
    chk("R3/R4/R7", "rts_n", rts_n, m_sel ? 1'b1 : outv);
    chk("R3/R4/R7", "dtr_n", dtr_n, m_sel ? outv : 1'b1);
    chk("R6", "tx_start", tx_start, tx_req && !tx_busy && !(m_acts && m_in()));
    chk("R5", "rx_irq", rx_irq, int'(rx_level) >= TRIG);
    chk("R8", "irq_flow", irq_flow, m_stat);
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    compare();
    {feat_we, ien_we, mctl_we, stat_rd} = '0;
  endtask

  task automatic wr(input int which, input logic [7:0] d);
    wdata = d;
    feat_we = (which == 0); ien_we = (which == 1); mctl_we = (which == 2);
    tick();
  endtask

  task automatic rand_run(input int n, input bit writes);
    for (int i = 0; i < n; i++) begin
      rx_level = LW'($urandom_range(0, 31));
      tx_req = 1'($urandom); tx_busy = 1'($urandom);
      if ($urandom_range(0, 5) == 0) cts_n = ~cts_n;
      if ($urandom_range(0, 5) == 0) dsr_n = ~dsr_n;
      stat_rd = ($urandom_range(0, 3) == 0);
      if (writes && $urandom_range(0, 9) == 0) begin
        wdata = 8'($urandom);
        case ($urandom_range(0, 2))
          0: feat_we = 1;
          1: ien_we = 1;
          default: mctl_we = 1;
        endcase
      end
      tick();
    end
  endtask

  always @(posedge clk) if (cyc > 150000) begin
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tx_req = 1;
    tick();
    // R1: reset state
    chk("R1", "rts_n", rts_n, 1'b0);
    chk("R1", "dtr_n", dtr_n, 1'b1);
    chk("R1", "irq_flow", irq_flow, 1'b0);
    chk("R1", "tx_start", tx_start, 1'b1);
    // R2: auto off, full FIFO keeps output low
    rx_level = 5'd31; tick(); tick();
    chk("R2", "rts_n", rts_n, 1'b0);
    // R9: locked write has no effect on the interrupt enable
    wr(1, 8'hC0);
    cts_n = 1; repeat (4) tick();
    chk("R9", "irq_flow", irq_flow, 1'b0);
    cts_n = 0; rx_level = 0;
    wr(0, 8'h10); wr(1, 8'hC0); wr(0, 8'hD0);
    // R3/R4 hysteresis sweep up and down
    for (int l = 0; l < 32; l++) begin rx_level = LW'(l); tick(); end
    chk("R3", "rts_n", rts_n, 1'b1);
    for (int l = 31; l >= 0; l--) begin
      rx_level = LW'(l); tick();
      if (l == LO + 1) chk("R4", "rts_n", rts_n, 1'b1);
    end
    chk("R4", "rts_n", rts_n, 1'b0);
    // R6: two-flop latency on the flow input, busy character not affected
    stat_rd = 1; tick();
    tx_req = 1; tx_busy = 0; cts_n = 1; tick();
    chk("R6", "tx_start", tx_start, 1'b1);
    tick();
    chk("R6", "tx_start", tx_start, 1'b0);
    tick();
    chk("R8", "irq_flow", irq_flow, 1'b1);
    stat_rd = 1; cts_n = 0; tick();
    chk("R8", "irq_flow", irq_flow, 1'b0);
    rand_run(400, 0);
    // R7: switch to the DTR/DSR pair
    wr(2, 8'h04);
    cts_n = 1; repeat (3) tick();
    chk("R7", "rts_n", rts_n, 1'b1);
    rand_run(400, 0);
    wr(2, 8'h00);
    rand_run(4000, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule